// File: doc/BRIEF.md
# Reloading Programmable Clock Divider

This block divides its clock by a ratio N between 2 and 64. A six-bit down counter holds the current count. A registered terminal-count flag is fed back as the counter's mode select. When the counter reaches its terminal value, the flag rises for one cycle. On the next edge the flag forces a parallel load of the divide value, and the counter then resumes counting. No external gating is needed for the reload.

The divide value is presented as N-1, because the load edge is itself one of the N clocks in a period. The divided output is low for one clock in every N clocks. A second output carries the opposite polarity.

A parameter selects a count-up variant. In that variant the counter loads the bitwise complement of the divide value and counts towards all ones, so the input encoding is the same in both variants. The divide value is sampled only on reload edges, so a new ratio takes effect at the next reload.

Top module: `clk_div_reload`

## Requirements
- R1: While the internal reset is active, div_o is 1 and div_no is 0. After rst_ni rises, div_o first goes low after the 66th rising edge of clk_i in the count-down variant (COUNT_UP=0). That is the reset-release synchronizer's 2 edges plus a full 64-state count from zero.
- R2: With divide value v (1 to 63, meaning N = v+1), successive low pulses on div_o start exactly N rising edges apart. For example, v=36 (binary 100100) gives N=37.
- R3: div_o is low for exactly one clock cycle per period and high for all other cycles.
- R4: div_no is always the logical complement of div_o.
- R5: div_val_i is sampled only at the rising edge that follows a low pulse (the reload edge). Changing it at any other time has no effect on the period in progress.
- R6: The extreme values work. v=1 (binary 000001) gives a period of 2 clocks, and v=63 (binary 111111) gives a period of 64 clocks.
- R7: With COUNT_UP=1, the counter loads ~v and counts up to all ones. The output periods are the same as in R2, and the first low pulse comes after the 65th rising edge following the release of rst_ni.
- R8: Asserting rst_ni low drives div_o high and div_no low at once, without a clock edge. After release, the sequence restarts as described in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_val_i | input | 6 | Divide value v = N-1, sampled on reload edges |
| div_o | output | 1 | Divided output, low for one cycle per period |
| div_no | output | 1 | Complement of div_o |

## Verification
A pulse on div_o is due at the rising edge that completes N edges after the previous pulse. The divide value that sets the next period is the one held across the edge immediately after a pulse. The first pulse after reset is due 66 edges after rst_ni rises in the down variant and 65 edges in the up variant. The bench drives all inputs and samples both outputs at the falling edge following each rising edge. It keeps an edge index and, for each variant, the expected index of the next pulse, and captures the divide value only on the modelled reload edge. Asynchronous reset is checked 1 ns after rst_ni falls, before any clock edge.

// File: rtl/clk_div_reload_pkg.sv
package clk_div_reload_pkg;

  // Mode select seen by the counter: the registered carry chooses between them.
  typedef enum logic {
    OP_COUNT = 1'b0,
    OP_LOAD  = 1'b1
  } cnt_op_e;

endpackage

// File: rtl/clk_div_rst_sync.sv
module clk_div_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/clk_div_step.sv
module clk_div_step
  import clk_div_reload_pkg::*;
#(
  parameter int unsigned WIDTH    = 6,
  parameter bit          COUNT_UP = 1'b0
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] preset_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] cnt_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] load_val;
  logic [WIDTH-1:0] step_val;

  generate
    if (COUNT_UP) begin : g_up
      // Complemented preset keeps the N-1 encoding for an up counter.
      assign load_val = ~preset_i;
      assign step_val = cnt_i + ONE;
    end else begin : g_down
      assign load_val = preset_i;
      assign step_val = cnt_i - ONE;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_LOAD:  cnt_o = load_val;
      default:  cnt_o = step_val;
    endcase
  end

endmodule

// File: rtl/clk_div_term.sv
module clk_div_term
  import clk_div_reload_pkg::*;
#(
  parameter int unsigned WIDTH    = 6,
  parameter bit          COUNT_UP = 1'b0
) (
  input  logic [WIDTH-1:0] cnt_nxt_i,
  input  cnt_op_e          op_i,
  output logic             tc_o
);

  localparam logic [WIDTH-1:0] TERM = COUNT_UP ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  // A loaded terminal value never raises the carry; only counting into it does.
  always_comb begin
    tc_o = (op_i == OP_COUNT) && (cnt_nxt_i == TERM);
  end

endmodule

// File: rtl/clk_div_reload.sv
module clk_div_reload
  import clk_div_reload_pkg::*;
#(
  parameter int unsigned WIDTH       = 6,
  parameter bit          COUNT_UP    = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] div_val_i,
  output logic             div_o,
  output logic             div_no
);

  localparam logic [WIDTH-1:0] TERM = COUNT_UP ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             rst_n_sync;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             tc_q;
  logic             tc_d;
  cnt_op_e          op;

  clk_div_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  // Registered carry fed back as the mode select.
  always_comb begin
    op = tc_q ? OP_LOAD : OP_COUNT;
  end

  clk_div_step #(
    .WIDTH    (WIDTH),
    .COUNT_UP (COUNT_UP)
  ) u_step (
    .cnt_i    (cnt_q),
    .preset_i (div_val_i),
    .op_i     (op),
    .cnt_o    (cnt_d)
  );

  clk_div_term #(
    .WIDTH    (WIDTH),
    .COUNT_UP (COUNT_UP)
  ) u_term (
    .cnt_nxt_i (cnt_d),
    .op_i      (op),
    .tc_o      (tc_d)
  );

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign div_o  = ~tc_q;
  assign div_no = tc_q;

  // R3: the carry never stays raised for two consecutive cycles.
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    tc_q |=> !tc_q);

  // R2: a raised carry is only seen while the count sits at its terminal value.
  a_r2_tc_at_term: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    tc_q |-> (cnt_q == TERM));

  generate
    if (COUNT_UP) begin : g_chk_up
      // R7: reload takes the complemented divide value.
      a_r7_reload_up: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        tc_q |=> (cnt_q == ~$past(div_val_i)));
      // R7: outside a reload the count moves up by one.
      a_r7_step_up: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        !tc_q |=> (cnt_q == $past(cnt_q) + ONE));
    end else begin : g_chk_down
      // R5: reload takes the divide value present at the reload edge.
      a_r5_reload_down: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        tc_q |=> (cnt_q == $past(div_val_i)));
      // R2: outside a reload the count moves down by one.
      a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        !tc_q |=> (cnt_q == $past(cnt_q) - ONE));
    end
  endgenerate

endmodule

// File: tb/tb_clk_div_reload.sv
`timescale 1ns/1ps
module tb_clk_div_reload;

  logic       clk;
  logic       rst_ni;
  logic [5:0] div_val;
  logic       dn_o, dn_no, up_o, up_no;

  int checks = 0;
  int errors = 0;
  int k;                 // rising edges since rst_ni release
  int np_dn, lp_dn;      // next / last expected pulse edge, down variant
  int np_up, lp_up;      // same, up variant
  bit changed_dn, changed_up;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  clk_div_reload #(.WIDTH(6), .COUNT_UP(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .div_val_i(div_val), .div_o(dn_o), .div_no(dn_no));

  clk_div_reload #(.WIDTH(6), .COUNT_UP(1'b1)) dut_up (
    .clk_i(clk), .rst_ni(rst_ni), .div_val_i(div_val), .div_o(up_o), .div_no(up_no));

  function automatic int first_pulse(input bit up);
    return up ? 65 : 66;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic model_reset();
    k = 0;
    np_dn = first_pulse(1'b0); lp_dn = -10;
    np_up = first_pulse(1'b1); lp_up = -10;
    changed_dn = 1'b0; changed_up = 1'b0;
  endtask

  function automatic string tag(input bit up, input bit pulse, input int lp,
                                input bit changed, input logic [5:0] v);
    if (up) return "R7";
    if (lp < 0) return "R1";
    if (changed) return "R5";
    if (v == 6'd1 || v == 6'd63) return "R6";
    return pulse ? "R2" : "R3";
  endfunction

  // mode 0: hold div_val; mode 1: random changes at any time
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      bit exp_dn, exp_up;
      @(posedge clk);
      k++;
      @(negedge clk);
      exp_dn = (k == np_dn);
      exp_up = (k == np_up);
      chk(tag(1'b0, exp_dn, lp_dn, changed_dn, div_val), dn_o, ~exp_dn);
      chk(tag(1'b1, exp_up, lp_up, changed_up, div_val), up_o, ~exp_up);
      chk("R4", dn_no, ~dn_o);
      chk("R4", up_no, ~up_o);
      if (exp_dn) lp_dn = k;
      if (exp_up) lp_up = k;
      if (k == lp_dn + 1) begin np_dn = k + int'(div_val); changed_dn = 1'b0; end
      if (k == lp_up + 1) begin np_up = k + int'(div_val); changed_up = 1'b0; end
      if (mode == 1 && $urandom_range(7, 0) == 0) begin
        div_val = 6'($urandom_range(63, 1));
        changed_dn = 1'b1;
        changed_up = 1'b1;
      end
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired at edge %0d", k);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1378));
    rst_ni  = 1'b0;
    div_val = 6'd36;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", dn_o, 1'b1);
    chk("R1", dn_no, 1'b0);
    chk("R1", up_o, 1'b1);
    rst_ni = 1'b1;
    run(300, 0);            // divide by 37
    div_val = 6'd1;
    run(60, 0);             // divide by 2
    div_val = 6'd63;
    run(300, 0);            // divide by 64
    div_val = 6'd4;
    run(2500, 1);           // random values with mid-period changes
    // R8: asynchronous reset mid-run
    @(negedge clk);
    div_val = 6'd36;
    while (dn_o !== 1'b0) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R8", dn_o, 1'b1);
    chk("R8", dn_no, 1'b0);
    chk("R8", up_o, 1'b1);
    chk("R8", up_no, 1'b0);
    repeat (3) @(negedge clk);
    model_reset();
    rst_ni = 1'b1;
    run(300, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule